// File: doc/BRIEF.md
# Banked Configuration Register File for a Multi-Channel DMA Engine

This block is the software-visible configuration store of a multi-channel DMA engine. It has one flat register window. Most of the state exists once per channel or once per port, but each such register has only one address. Software first writes a channel number into a select register. Every later access to the per-channel offsets then reaches that channel's private copy. Port control uses the same scheme with a separate port-select register.

Each channel holds the following state: an enable flag, a direction flag, a two-bit weight, a polling setup, a descriptor ring base, a descriptor count, a set of interrupt-cause enables and a set of interrupt-status flags. A channel can be reset by software. This reset is a command bit that stays set for a fixed number of cycles and then clears itself, so a driver can poll it. Every channel has an event input that marks one descriptor as complete. A single level output combines all pending, enabled causes, and a global per-channel bitmap gates that output. The block contains only the registers. Descriptor fetch, bus mastering and arbitration are in the engine that consumes its outputs.

Top module: `dma_cfg_regs`

## Requirements
- R1: After reset, every readable offset other than 0x08 reads zero and `irq_out` is low.
- R2: Offset 0x08 is read-only and reads the revision in bits 4:0, the port count (4) in bits 19:16 and the channel count (20) in bits 31:20, which gives 0x01440001.
- R3: Offsets 0x14 and 0x1C to 0x2C reach the channel whose number was last written to offset 0x18. Offset 0x18 reads back the written bits 7:0. Channel control keeps bit 0 (on), bit 8 (transmit) and bits 17:16 (weight). Poll keeps bit 31 (polling on) and bit 6 (divide by 4). Descriptor base keeps all 32 bits. Descriptor count keeps bits 15:0.
- R4: While the channel select holds 20 or more, the per-channel offsets read zero and writes to them change no channel.
- R5: A write to channel control with bit 1 set loads the other fields and starts a channel reset. Bit 1 reads 1 after that clock edge and for 3 more cycles, and clears at the 4th edge. At that edge the channel's control, poll and status fields return to zero, while base, count and cause enables keep their values. Writes to channel control while bit 1 reads 1 are ignored.
- R6: A high `ch_event[n]` at a clock edge sets bit 3 (descriptor complete) of channel n's status at offset 0x28. No other status bit is ever set.
- R7: A write to offset 0x28 clears each status bit 6:1 of the selected channel whose written bit is 1. If an event arrives in the same cycle, the event wins and bit 3 stays set.
- R8: Offset 0x2C keeps the cause enables in bits 6:1 and reads zero elsewhere.
- R9: `irq_out` is high exactly when some channel n has a status bit that is also enabled at 0x2C, and bit n of offset 0xF4 is set.
- R10: Offset 0xF4 holds one read/write enable bit per channel in bits 19:0.
- R11: Offset 0x44 reaches the port selected at offset 0x40. It keeps bits 11:8 (swap), bit 6 (drop) and bits 5:4 and 3:2 (burst lengths), so writing all ones reads 0x00000F7C. A port select of 4 or more reads zero at 0x44 and ignores writes there.
- R12: Writing bit 0 of offset 0x10 makes it read 1 in the next cycle. At the following edge, every register returns to its reset value and bit 0 reads 0 again.
- R13: Offsets not named above read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ch_event | input | 20 | Descriptor-complete event, one per channel |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two functions can act on the same status flag in one cycle: an acknowledge write to the status offset and a descriptor-complete event on the same channel. A directed step drives both together on one clock edge and then reads the status back. The flag must still be set, and a later acknowledge with no event must clear it. Channel reset completion also competes with a pending event, and random traffic that injects sparse events while acknowledging keeps both paths busy. Every read is compared with a bench model that applies the clear before the set.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

   // Register offsets (byte addresses inside the window)
   localparam logic [7:0] OFF_ID    = 8'h08;
   localparam logic [7:0] OFF_GCTL  = 8'h10;
   localparam logic [7:0] OFF_POLL  = 8'h14;
   localparam logic [7:0] OFF_CSEL  = 8'h18;
   localparam logic [7:0] OFF_CCTL  = 8'h1C;
   localparam logic [7:0] OFF_DBASE = 8'h20;
   localparam logic [7:0] OFF_DCNT  = 8'h24;
   localparam logic [7:0] OFF_ISTAT = 8'h28;
   localparam logic [7:0] OFF_IEN   = 8'h2C;
   localparam logic [7:0] OFF_PSEL  = 8'h40;
   localparam logic [7:0] OFF_PCTL  = 8'h44;
   localparam logic [7:0] OFF_GIEN  = 8'hF4;

   // Channel control bit positions
   localparam int CC_ON     = 0;
   localparam int CC_RST    = 1;
   localparam int CC_DIR    = 8;
   localparam int CC_WT_LO  = 16;

   // Poll bit positions
   localparam int PL_EN     = 31;
   localparam int PL_DIV4   = 6;

   // Interrupt cause field: bits 6:1
   localparam int CAUSE_LSB = 1;
   localparam int CAUSE_W   = 6;
   localparam int CAUSE_DESC = 3;

   // Global control
   localparam int GC_RST    = 0;

   // Port control field base: the port receives wdata[11:2]
   localparam int PC_LSB    = 2;
   localparam int PC_W      = 10;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_ID, SEL_GCTL, SEL_POLL, SEL_CSEL, SEL_CCTL, SEL_DBASE,
      SEL_DCNT, SEL_ISTAT, SEL_IEN, SEL_PSEL, SEL_PCTL, SEL_GIEN
   } reg_sel_e;

   function automatic reg_sel_e decode_off(input logic [7:0] a);
      case (a)
         OFF_ID:    return SEL_ID;
         OFF_GCTL:  return SEL_GCTL;
         OFF_POLL:  return SEL_POLL;
         OFF_CSEL:  return SEL_CSEL;
         OFF_CCTL:  return SEL_CCTL;
         OFF_DBASE: return SEL_DBASE;
         OFF_DCNT:  return SEL_DCNT;
         OFF_ISTAT: return SEL_ISTAT;
         OFF_IEN:   return SEL_IEN;
         OFF_PSEL:  return SEL_PSEL;
         OFF_PCTL:  return SEL_PCTL;
         OFF_GIEN:  return SEL_GIEN;
         default:   return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/dma_cfg_chan.sv
module dma_cfg_chan
   import dma_cfg_pkg::*;
#(
   parameter int DCNT_W     = 16,
   parameter int RST_CYCLES = 4
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_clr,
   input  logic        sel,
   input  logic        wr,
   input  reg_sel_e    rsel,
   input  logic [31:0] wdata,
   input  logic        evt,
   output logic [31:0] rd_o,
   output logic        busy_o,
   output logic        desc_done_o,
   output logic        irq_req_o
);

   localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(RST_CYCLES - 1);
   localparam int EVT_POS = CAUSE_DESC - CAUSE_LSB;

   logic              on_q, dir_q;
   logic [1:0]        wt_q;
   logic              busy_q;
   logic [CNT_W-1:0]  rcnt_q;
   logic              pl_en_q, pl_div_q;
   logic [31:0]       base_q;
   logic [DCNT_W-1:0] cnt_q;
   logic [CAUSE_W-1:0] stat_q, ien_q;

   logic wr_ctl, wr_poll, wr_base, wr_cnt, wr_stat, wr_ien, rst_done;
   logic [CAUSE_W-1:0] clr_vec, set_vec;

   assign wr_ctl   = sel && wr && (rsel == SEL_CCTL) && !busy_q;
   assign wr_poll  = sel && wr && (rsel == SEL_POLL);
   assign wr_base  = sel && wr && (rsel == SEL_DBASE);
   assign wr_cnt   = sel && wr && (rsel == SEL_DCNT);
   assign wr_stat  = sel && wr && (rsel == SEL_ISTAT);
   assign wr_ien   = sel && wr && (rsel == SEL_IEN);
   assign rst_done = busy_q && (rcnt_q == '0);

   assign clr_vec = wr_stat ? wdata[CAUSE_LSB +: CAUSE_W] : '0;
   assign set_vec = CAUSE_W'({5'd0, evt}) << EVT_POS;

   // control word and reset sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q <= 1'b0; dir_q <= 1'b0; wt_q <= '0; busy_q <= 1'b0; rcnt_q <= '0;
      end else if (soft_clr || rst_done) begin
         on_q <= 1'b0; dir_q <= 1'b0; wt_q <= '0; busy_q <= 1'b0; rcnt_q <= '0;
      end else if (wr_ctl) begin
         on_q  <= wdata[CC_ON];
         dir_q <= wdata[CC_DIR];
         wt_q  <= wdata[CC_WT_LO +: 2];
         if (wdata[CC_RST]) begin
            busy_q <= 1'b1;
            rcnt_q <= RC_LOAD;
         end
      end else if (busy_q) begin
         rcnt_q <= rcnt_q - 1'b1;
      end
   end

   // poll setup, cleared by channel reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pl_en_q <= 1'b0; pl_div_q <= 1'b0;
      end else if (soft_clr || rst_done) begin
         pl_en_q <= 1'b0; pl_div_q <= 1'b0;
      end else if (wr_poll) begin
         pl_en_q  <= wdata[PL_EN];
         pl_div_q <= wdata[PL_DIV4];
      end
   end

   // descriptor ring setup, kept across channel reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0; cnt_q <= '0; ien_q <= '0;
      end else if (soft_clr) begin
         base_q <= '0; cnt_q <= '0; ien_q <= '0;
      end else begin
         if (wr_base) base_q <= wdata;
         if (wr_cnt)  cnt_q  <= wdata[DCNT_W-1:0];
         if (wr_ien)  ien_q  <= wdata[CAUSE_LSB +: CAUSE_W];
      end
   end

   // status: clear first, then a new event re-sets (event wins)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    stat_q <= '0;
      else if (soft_clr || rst_done) stat_q <= '0;
      else                           stat_q <= (stat_q & ~clr_vec) | set_vec;
   end

   always_comb begin
      rd_o = '0;
      case (rsel)
         SEL_POLL: begin
            rd_o[PL_EN]   = pl_en_q;
            rd_o[PL_DIV4] = pl_div_q;
         end
         SEL_CCTL: begin
            rd_o[CC_ON]          = on_q;
            rd_o[CC_RST]         = busy_q;
            rd_o[CC_DIR]         = dir_q;
            rd_o[CC_WT_LO +: 2]  = wt_q;
         end
         SEL_DBASE: rd_o = base_q;
         SEL_DCNT:  rd_o[DCNT_W-1:0] = cnt_q;
         SEL_ISTAT: rd_o[CAUSE_LSB +: CAUSE_W] = stat_q;
         SEL_IEN:   rd_o[CAUSE_LSB +: CAUSE_W] = ien_q;
         default:   rd_o = '0;
      endcase
   end

   assign busy_o      = busy_q;
   assign desc_done_o = stat_q[EVT_POS];
   assign irq_req_o   = |(stat_q & ien_q);

endmodule

// File: rtl/dma_cfg_port.sv
module dma_cfg_port
   import dma_cfg_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_clr,
   input  logic            sel,
   input  logic            wr,
   input  reg_sel_e        rsel,
   input  logic [PC_W-1:0] wfield,
   output logic [31:0]     rd_o
);

   // wfield bit k corresponds to register bit k+PC_LSB
   logic [3:0] swap_q;
   logic       drop_q;
   logic [1:0] burst_hi_q, burst_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swap_q <= '0; drop_q <= 1'b0; burst_hi_q <= '0; burst_lo_q <= '0;
      end else if (soft_clr) begin
         swap_q <= '0; drop_q <= 1'b0; burst_hi_q <= '0; burst_lo_q <= '0;
      end else if (sel && wr && rsel == SEL_PCTL) begin
         swap_q     <= wfield[9:6];
         drop_q     <= wfield[4];
         burst_hi_q <= wfield[3:2];
         burst_lo_q <= wfield[1:0];
      end
   end

   always_comb begin
      rd_o = '0;
      if (rsel == SEL_PCTL) begin
         rd_o[11:8] = swap_q;
         rd_o[6]    = drop_q;
         rd_o[5:4]  = burst_hi_q;
         rd_o[3:2]  = burst_lo_q;
      end
   end

endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
   import dma_cfg_pkg::*;
#(
   parameter int NUM_CH     = 20,
   parameter int NUM_PORT   = 4,
   parameter int HW_REV     = 1,
   parameter int DCNT_W     = 16,
   parameter int RST_CYCLES = 4,
   parameter int SEL_W      = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NUM_CH-1:0] ch_event,
   output logic              irq_out
);

   localparam int CS_IDX_W = $clog2(NUM_CH);
   localparam int PS_IDX_W = $clog2(NUM_PORT);
   localparam logic [31:0] ID_WORD =
      {12'(NUM_CH), 4'(NUM_PORT), 11'd0, 5'(HW_REV)};

   if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_nch
      $error("NUM_CH must lie in 2..32");
   end
   if (NUM_PORT < 2 || NUM_PORT > 15) begin : g_bad_nport
      $error("NUM_PORT must lie in 2..15");
   end
   if (RST_CYCLES < 1 || RST_CYCLES > 255) begin : g_bad_rst
      $error("RST_CYCLES must lie in 1..255");
   end
   if (DCNT_W < 1 || DCNT_W > 32) begin : g_bad_dcnt
      $error("DCNT_W must lie in 1..32");
   end
   if (SEL_W <= CS_IDX_W || SEL_W <= PS_IDX_W || SEL_W > 32) begin : g_bad_sel
      $error("SEL_W too narrow or too wide");
   end

   reg_sel_e          rsel;
   logic [SEL_W-1:0]  cs_q, ps_q;
   logic [NUM_CH-1:0] gen_q;
   logic              soft_clr_q;
   logic              cs_ok, ps_ok;

   assign rsel  = decode_off(reg_addr);
   assign cs_ok = cs_q < SEL_W'(NUM_CH);
   assign ps_ok = ps_q < SEL_W'(NUM_PORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_clr_q <= 1'b0;
      else        soft_clr_q <= reg_wr && (rsel == SEL_GCTL) && reg_wdata[GC_RST];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= '0; ps_q <= '0; gen_q <= '0;
      end else if (soft_clr_q) begin
         cs_q <= '0; ps_q <= '0; gen_q <= '0;
      end else if (reg_wr) begin
         if (rsel == SEL_CSEL) cs_q  <= reg_wdata[SEL_W-1:0];
         if (rsel == SEL_PSEL) ps_q  <= reg_wdata[SEL_W-1:0];
         if (rsel == SEL_GIEN) gen_q <= reg_wdata[NUM_CH-1:0];
      end
   end

   // channel banks
   logic [31:0]       ch_rd [NUM_CH];
   logic [NUM_CH-1:0] busy_vec, desc_done_vec, irq_req;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dma_cfg_chan #(
         .DCNT_W     (DCNT_W),
         .RST_CYCLES (RST_CYCLES)
      ) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .soft_clr    (soft_clr_q),
         .sel         (cs_ok && (cs_q == SEL_W'(i))),
         .wr          (reg_wr),
         .rsel        (rsel),
         .wdata       (reg_wdata),
         .evt         (ch_event[i]),
         .rd_o        (ch_rd[i]),
         .busy_o      (busy_vec[i]),
         .desc_done_o (desc_done_vec[i]),
         .irq_req_o   (irq_req[i])
      );
   end

   // port banks
   logic [31:0] pt_rd [NUM_PORT];

   for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
      dma_cfg_port u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_clr (soft_clr_q),
         .sel      (ps_ok && (ps_q == SEL_W'(p))),
         .wr       (reg_wr),
         .rsel     (rsel),
         .wfield   (reg_wdata[PC_LSB +: PC_W]),
         .rd_o     (pt_rd[p])
      );
   end

   logic [31:0] ch_word, pt_word;
   assign ch_word = cs_ok ? ch_rd[cs_q[CS_IDX_W-1:0]] : '0;
   assign pt_word = ps_ok ? pt_rd[ps_q[PS_IDX_W-1:0]] : '0;

   always_comb begin
      case (rsel)
         SEL_ID:    reg_rdata = ID_WORD;
         SEL_GCTL:  reg_rdata = {31'd0, soft_clr_q};
         SEL_CSEL:  reg_rdata = 32'(cs_q);
         SEL_PSEL:  reg_rdata = 32'(ps_q);
         SEL_GIEN:  reg_rdata = 32'(gen_q);
         SEL_POLL, SEL_CCTL, SEL_DBASE, SEL_DCNT, SEL_ISTAT, SEL_IEN:
                    reg_rdata = ch_word;
         SEL_PCTL:  reg_rdata = pt_word;
         default:   reg_rdata = '0;
      endcase
   end

   assign irq_out = |(irq_req & gen_q);

endmodule

// File: rtl/dma_cfg_regs_chk.sv
module dma_cfg_regs_chk #(
   parameter int NUM_CH     = 20,
   parameter int NUM_PORT   = 4,
   parameter int HW_REV     = 1,
   parameter int RST_CYCLES = 4,
   parameter int SEL_W      = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [7:0]        reg_addr,
   input logic              w1c_bit,
   input logic [31:0]       reg_rdata,
   input logic [NUM_CH-1:0] ch_event,
   input logic              irq_out,
   input logic [SEL_W-1:0]  cs_q,
   input logic              soft_clr_q,
   input logic [NUM_CH-1:0] gen_q,
   input logic [NUM_CH-1:0] busy_vec,
   input logic [NUM_CH-1:0] desc_done_vec
);

   localparam logic [31:0] ID_EXP =
      {12'(NUM_CH), 4'(NUM_PORT), 11'd0, 5'(HW_REV)};

   logic ch_off;
   assign ch_off = (reg_addr == 8'h14) || (reg_addr == 8'h1C) ||
                   (reg_addr == 8'h20) || (reg_addr == 8'h24) ||
                   (reg_addr == 8'h28) || (reg_addr == 8'h2C);

   // counts how long channel 0 stays in reset
   logic [7:0] bcnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bcnt <= '0;
      else if (busy_vec[0]) bcnt <= bcnt + 1'b1;
      else                 bcnt <= '0;
   end

   assert_id_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 8'h08) |-> (reg_rdata == ID_EXP));

   assert_bad_sel_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_off && cs_q >= SEL_W'(NUM_CH)) |-> (reg_rdata == 32'd0));

   assert_rst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_vec[0]) && !$past(soft_clr_q)) |-> (bcnt == 8'(RST_CYCLES)));

   assert_evt_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_event[0] && !busy_vec[0] && !soft_clr_q) |=> desc_done_vec[0]);

   assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 8'h28 && cs_q == '0 && w1c_bit && !ch_event[0])
      |=> !desc_done_vec[0]);

   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (|(gen_q & desc_done_vec)));

   assert_engine_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr_q |=> (gen_q == '0 && cs_q == '0 && busy_vec == '0));

endmodule

bind dma_cfg_regs dma_cfg_regs_chk #(
   .NUM_CH     (NUM_CH),
   .NUM_PORT   (NUM_PORT),
   .HW_REV     (HW_REV),
   .RST_CYCLES (RST_CYCLES),
   .SEL_W      (SEL_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr        (reg_wr),
   .reg_addr      (reg_addr),
   .w1c_bit       (reg_wdata[3]),
   .reg_rdata     (reg_rdata),
   .ch_event      (ch_event),
   .irq_out       (irq_out),
   .cs_q          (cs_q),
   .soft_clr_q    (soft_clr_q),
   .gen_q         (gen_q),
   .busy_vec      (busy_vec),
   .desc_done_vec (desc_done_vec)
);

// File: tb/dma_cfg_regs_test.sv
`timescale 1ns/1ps
module dma_cfg_regs_test;

   localparam int NCH = 20;
   localparam int NPT = 4;
   localparam logic [31:0] ID_VAL = 32'h0144_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCH-1:0] ch_event = '0;
   logic        irq_out;

   always #10 clk = ~clk;

   dma_cfg_regs uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_event(ch_event),
      .irq_out(irq_out)
   );

   int n_chk = 0;
   int n_fail = 0;

   // bench model, values kept in read format
   logic [7:0]  m_cs, m_ps;
   logic [19:0] m_gen;
   logic [31:0] m_ctrl [NCH];
   logic [31:0] m_poll [NCH];
   logic [31:0] m_base [NCH];
   logic [31:0] m_cnt  [NCH];
   logic [31:0] m_stat [NCH];
   logic [31:0] m_ien  [NCH];
   logic [31:0] m_pc   [NPT];

   function automatic void model_clear();
      m_cs = '0; m_ps = '0; m_gen = '0;
      for (int i = 0; i < NCH; i++) begin
         m_ctrl[i] = '0; m_poll[i] = '0; m_base[i] = '0;
         m_cnt[i] = '0; m_stat[i] = '0; m_ien[i] = '0;
      end
      for (int p = 0; p < NPT; p++) m_pc[p] = '0;
   endfunction

   function automatic void model_apply(bit wr, logic [7:0] a, logic [31:0] d,
                                       logic [NCH-1:0] ev);
      bit csv = (m_cs < NCH);
      for (int i = 0; i < NCH; i++) begin
         logic [31:0] clr = (wr && a == 8'h28 && csv && m_cs == i) ? (d & 32'h7E) : 32'h0;
         m_stat[i] = (m_stat[i] & ~clr) | (ev[i] ? 32'h8 : 32'h0);
      end
      if (wr) begin
         case (a)
            8'h18: m_cs = d[7:0];
            8'h40: m_ps = d[7:0];
            8'hF4: m_gen = d[19:0];
            8'h14: if (csv) m_poll[m_cs] = d & 32'h8000_0040;
            8'h1C: if (csv) m_ctrl[m_cs] = d & 32'h0003_0101;
            8'h20: if (csv) m_base[m_cs] = d;
            8'h24: if (csv) m_cnt[m_cs]  = d & 32'h0000_FFFF;
            8'h2C: if (csv) m_ien[m_cs]  = d & 32'h7E;
            8'h44: if (m_ps < NPT) m_pc[m_ps] = d & 32'h0F7C;
            default: ;
         endcase
      end
   endfunction

   function automatic logic [31:0] exp_rd(logic [7:0] a);
      bit csv = (m_cs < NCH);
      case (a)
         8'h08: return ID_VAL;
         8'h14: return csv ? m_poll[m_cs] : 32'h0;
         8'h18: return {24'h0, m_cs};
         8'h1C: return csv ? m_ctrl[m_cs] : 32'h0;
         8'h20: return csv ? m_base[m_cs] : 32'h0;
         8'h24: return csv ? m_cnt[m_cs]  : 32'h0;
         8'h28: return csv ? m_stat[m_cs] : 32'h0;
         8'h2C: return csv ? m_ien[m_cs]  : 32'h0;
         8'h40: return {24'h0, m_ps};
         8'h44: return (m_ps < NPT) ? m_pc[m_ps] : 32'h0;
         8'hF4: return {12'h0, m_gen};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic exp_irq();
      logic r = 1'b0;
      for (int i = 0; i < NCH; i++)
         if (((m_stat[i] & m_ien[i]) != 0) && m_gen[i]) r = 1'b1;
      return r;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(bit wr, logic [7:0] a, logic [31:0] d, logic [NCH-1:0] ev);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; ch_event = ev;
      @(posedge clk);
      #1;
      model_apply(wr, a, d, ev);
   endtask

   task automatic rd_chk(string req, logic [7:0] a);
      @(negedge clk);
      reg_wr = 1'b0; ch_event = '0; reg_addr = a;
      #1;
      check(req, reg_rdata, exp_rd(a));
   endtask

   task automatic irq_chk(string req);
      @(negedge clk);
      reg_wr = 1'b0; ch_event = '0;
      #1;
      check(req, {31'd0, irq_out}, {31'd0, exp_irq()});
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all): actual timeout expected completion");
      summary();
      $finish;
   end

   logic [7:0] pool [12] = '{8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28,
                             8'h2C, 8'h40, 8'h44, 8'hF4, 8'h08, 8'h30};

   initial begin
      void'($urandom(32'd1234));
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      foreach (pool[k]) if (pool[k] != 8'h08) rd_chk("R1", pool[k]);
      rd_chk("R1", 8'h10);
      irq_chk("R1");

      // R2 identification
      rd_chk("R2", 8'h08);

      // R3 banking by channel select
      step(1, 8'h18, 32'd0, '0);  step(1, 8'h20, 32'hA5A5_0001, '0);
      step(1, 8'h1C, 32'hFFFF_FFFD, '0); step(1, 8'h14, 32'hFFFF_FFFF, '0);
      step(1, 8'h24, 32'hFFFF_FFFF, '0);
      step(1, 8'h18, 32'd1, '0);  step(1, 8'h20, 32'h5A5A_0002, '0);
      rd_chk("R3", 8'h20); rd_chk("R3", 8'h1C);
      step(1, 8'h18, 32'd0, '0);
      rd_chk("R3", 8'h20); rd_chk("R3", 8'h1C); rd_chk("R3", 8'h14);
      rd_chk("R3", 8'h24); rd_chk("R3", 8'h18);

      // R8 cause enable field
      step(1, 8'h2C, 32'hFFFF_FFFF, '0);
      rd_chk("R8", 8'h2C);

      // R10 global enable bitmap
      step(1, 8'hF4, 32'hFFFF_FFFF, '0);
      rd_chk("R10", 8'hF4);
      step(1, 8'hF4, 32'h0, '0);
      rd_chk("R10", 8'hF4);

      // R4 out-of-range channel select
      step(1, 8'h18, 32'd20, '0);
      step(1, 8'h20, 32'hDEAD_BEEF, '0);
      rd_chk("R4", 8'h20);
      step(1, 8'h18, 32'd31, '0);
      step(1, 8'h1C, 32'h0003_0101, '0);
      rd_chk("R4", 8'h1C);
      step(1, 8'h18, 32'd19, '0);
      rd_chk("R4", 8'h20); rd_chk("R4", 8'h1C);

      // R11 port banking
      step(1, 8'h40, 32'd2, '0); step(1, 8'h44, 32'hFFFF_FFFF, '0);
      rd_chk("R11", 8'h44);
      step(1, 8'h40, 32'd1, '0); rd_chk("R11", 8'h44);
      step(1, 8'h40, 32'd4, '0); step(1, 8'h44, 32'hFFFF_FFFF, '0);
      rd_chk("R11", 8'h44);
      step(1, 8'h40, 32'd2, '0); rd_chk("R11", 8'h44);

      // R13 unmapped offsets
      step(1, 8'h30, 32'hFFFF_FFFF, '0);
      rd_chk("R13", 8'h30); rd_chk("R13", 8'h00); rd_chk("R13", 8'hFC);

      // R6 / R7 / R9 event versus acknowledge on channel 5
      step(1, 8'h18, 32'd5, '0);
      step(1, 8'h2C, 32'h08, '0);
      step(1, 8'hF4, 32'h20, '0);
      step(0, 8'h00, 32'h0, 20'h00020);
      rd_chk("R6", 8'h28);
      irq_chk("R9");
      step(1, 8'h28, 32'h7E, 20'h00020);
      rd_chk("R7", 8'h28);
      step(1, 8'h28, 32'h7E, '0);
      rd_chk("R7", 8'h28);
      irq_chk("R9");
      step(0, 8'h00, 32'h0, 20'h00020);
      step(1, 8'hF4, 32'h0, '0);
      irq_chk("R9");
      step(1, 8'hF4, 32'h20, '0);
      irq_chk("R9");
      step(1, 8'h2C, 32'h0, '0);
      irq_chk("R9");

      // R5 channel reset on channel 3
      step(1, 8'h18, 32'd3, '0);
      step(1, 8'h14, 32'h8000_0040, '0);
      step(1, 8'h20, 32'h1234_5678, '0);
      step(1, 8'h24, 32'h40, '0);
      step(1, 8'h2C, 32'h08, '0);
      step(1, 8'h1C, 32'h0003_0101, '0);
      step(0, 8'h00, 32'h0, 20'h00008);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'h0003_0103; ch_event = '0;
      @(posedge clk);
      @(negedge clk);
      reg_wdata = 32'h0000_0001;
      #1; check("R5", reg_rdata, 32'h0003_0103);
      @(negedge clk);
      reg_wr = 1'b0;
      #1; check("R5", reg_rdata, 32'h0003_0103);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); #1; check("R5", reg_rdata, 32'h0003_0103);
      end
      @(negedge clk); #1; check("R5", reg_rdata, 32'h0);
      m_ctrl[3] = '0; m_poll[3] = '0; m_stat[3] = '0;
      rd_chk("R5", 8'h14); rd_chk("R5", 8'h28); rd_chk("R5", 8'h20);
      rd_chk("R5", 8'h24); rd_chk("R5", 8'h2C);

      // random traffic
      for (int it = 0; it < 400; it++) begin
         logic [7:0]  a = pool[$urandom_range(0, 11)];
         logic [31:0] d = $urandom;
         logic [NCH-1:0] ev = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
         if (a == 8'h18) d = 32'($urandom_range(0, 23));
         if (a == 8'h40) d = 32'($urandom_range(0, 5));
         if (a == 8'h1C) d = d & ~32'h2;
         if (a == 8'h28 && $urandom_range(0, 1) == 0) d = 32'h7E;
         step(1, a, d, ev);
         rd_chk("R3", pool[$urandom_range(0, 11)]);
         irq_chk("R9");
      end

      // R12 engine reset
      step(1, 8'h10, 32'h1, '0);
      @(negedge clk); reg_wr = 1'b0; reg_addr = 8'h10;
      #1; check("R12", reg_rdata, 32'h1);
      @(negedge clk);
      #1; check("R12", reg_rdata, 32'h0);
      model_clear();
      rd_chk("R12", 8'hF4); rd_chk("R12", 8'h18); rd_chk("R12", 8'h40);
      rd_chk("R12", 8'h20); rd_chk("R12", 8'h2C);
      irq_chk("R12");

      summary();
      $finish;
   end

endmodule